// File: doc/BRIEF.md
# Interrupt CPU Interface Priority Logic

This block sits between a vector of pending interrupt requests and one processing element. Each cycle it scans the pending lines, excluding any interrupt that is already active, and finds the most urgent one. It reports that interrupt's ID as the highest pending ID without changing any state. It raises the interrupt request line when that interrupt passes both the priority mask and the preemption test.

Software-style request strobes drive the rest of the flow. An acknowledge returns the selected ID, or the spurious ID 1023 when nothing is eligible. It marks the interrupt active and records its group priority in an active-priority bitmap. An end-of-interrupt strobe performs only the priority drop, which lowers the running priority. A separate deactivate strobe, carrying an ID, returns that interrupt from the active state so it can be selected again. Two further strobes load the priority mask and the binary point. The binary point sets how many low priority bits are ignored when the group priority is formed.

Top module: `cpuif_prio`

## Requirements
- R1: After reset, ackId is 1023, runPrio is 0xFF, the priority mask is 0x00 (so irqOut stays low whatever is pending) and the binary point is 0.
- R2: hiPendId gives the ID of the pending, not active interrupt with the numerically lowest 8-bit priority. Ties go to the lowest ID. It reads 1023 when no such interrupt exists, and it never changes state.
- R3: An acknowledge while irqOut is high loads ackId with hiPendId and marks that interrupt active from the next cycle. An acknowledge while irqOut is low loads ackId with 1023 and changes nothing else.
- R4: runPrio is the lowest-numbered group priority held in the active-priority bitmap, or 0xFF when the bitmap is empty. An acknowledge sets the bit of the taken interrupt's group priority.
- R5: An end-of-interrupt strobe clears the lowest-numbered set bit of the bitmap, so runPrio rises. It leaves the interrupt active, and an active interrupt is not selected again.
- R6: A deactivate strobe clears the active flag of the interrupt whose ID is on deactId and leaves runPrio unchanged. An ID at or above the interrupt count is ignored.
- R7: A pending interrupt raises irqOut only when its priority is strictly below the mask (mask-load strobe, 8-bit value).
- R8: The group priority is the priority with its low B bits cleared, where B is the binary point value 0 to 7 (binary-point-load strobe, 3-bit value). Preemption requires the group priority to be strictly below runPrio.
- R9: irqOut is high exactly when a candidate exists in the sense of R2 and that candidate satisfies both R7 and R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pendVec | input | NUM_IRQ | Pending request per interrupt |
| prioFlat | input | 8*NUM_IRQ | Priority of interrupt i in bits [8i+7:8i] |
| ackReq | input | 1 | Acknowledge strobe |
| eoiReq | input | 1 | Priority-drop strobe |
| deactReq | input | 1 | Deactivate strobe |
| deactId | input | 10 | ID to deactivate |
| maskWe | input | 1 | Load priority mask |
| maskData | input | 8 | New mask value |
| bprWe | input | 1 | Load binary point |
| bprData | input | 3 | New binary point |
| irqOut | output | 1 | Interrupt request to the processing element |
| ackId | output | 10 | ID returned by the last acknowledge |
| runPrio | output | 8 | Current running priority |
| hiPendId | output | 10 | Highest-priority pending ID, 1023 if none |

## Verification
A stale active flag shows at the ports one cycle after the strobe that should have changed it. hiPendId either skips a pending interrupt that should be visible or keeps returning one that should be masked out. A wrong bit in the active-priority bitmap shows up in runPrio on the cycle after the acknowledge or end-of-interrupt. In that same cycle irqOut also flips against the group-priority rule. The bench steps through nested acknowledges, drops in lowest-first order and late deactivation, reading all four outputs after every strobe.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  localparam int PRIO_W = 8;
  localparam int ID_W = 10;
  localparam int GRP_N = 1 << PRIO_W;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
  localparam logic [PRIO_W-1:0] IDLE_PRIO = 8'hFF;

  typedef struct packed {
    logic ackTake;
    logic ackNone;
    logic dropTake;
    logic deactTake;
    logic maskLoad;
    logic bprLoad;
  } ctrlStrobe_t;
endpackage

// File: rtl/cpuif_ctrl.sv
module cpuif_ctrl
  import cpuif_pkg::*;
(
  input  logic              ackReq,
  input  logic              eoiReq,
  input  logic              deactReq,
  input  logic              maskWe,
  input  logic              bprWe,
  input  logic              found,
  input  logic [PRIO_W-1:0] bestPrio,
  input  logic [PRIO_W-1:0] bestGrp,
  input  logic [PRIO_W-1:0] runPrio,
  input  logic [PRIO_W-1:0] maskVal,
  output ctrlStrobe_t       strb,
  output logic              irqOut
);
  logic passMask;
  logic passPreempt;

  always_comb begin
    passMask    = bestPrio < maskVal;
    passPreempt = bestGrp < runPrio;
    irqOut      = found && passMask && passPreempt;
    strb.ackTake   = ackReq && irqOut;
    strb.ackNone   = ackReq && !irqOut;
    strb.dropTake  = eoiReq;
    strb.deactTake = deactReq;
    strb.maskLoad  = maskWe;
    strb.bprLoad   = bprWe;
  end
endmodule

// File: rtl/cpuif_dp.sv
module cpuif_dp
  import cpuif_pkg::*;
#(
  parameter int NUM_IRQ = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobe_t               strb,
  input  logic [NUM_IRQ-1:0]        pendVec,
  input  logic [NUM_IRQ*PRIO_W-1:0] prioFlat,
  input  logic [ID_W-1:0]           deactId,
  input  logic [PRIO_W-1:0]         maskData,
  input  logic [2:0]                bprData,
  output logic                      found,
  output logic [PRIO_W-1:0]         bestPrio,
  output logic [PRIO_W-1:0]         bestGrp,
  output logic [PRIO_W-1:0]         runPrio,
  output logic [PRIO_W-1:0]         maskReg,
  output logic [ID_W-1:0]           hiPendId,
  output logic [ID_W-1:0]           ackId
);
  logic [PRIO_W-1:0] prioArr [NUM_IRQ];
  logic [NUM_IRQ-1:0] activeVec;
  logic [NUM_IRQ-1:0] candVec;
  logic [GRP_N-1:0]   apBits;
  logic [GRP_N-1:0]   apNext;
  logic [2:0]         bprReg;
  logic [ID_W-1:0]    bestIdx;
  logic [PRIO_W-1:0]  grpMask;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_prio
    assign prioArr[g] = prioFlat[g*PRIO_W +: PRIO_W];
  end

  assign candVec = pendVec & ~activeVec;
  assign grpMask = IDLE_PRIO << bprReg;

  // Winner search: strict compare in ascending ID order keeps the lowest ID on ties.
  always_comb begin
    found    = 1'b0;
    bestPrio = IDLE_PRIO;
    bestIdx  = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (candVec[i] && (!found || prioArr[i] < bestPrio)) begin
        found    = 1'b1;
        bestPrio = prioArr[i];
        bestIdx  = ID_W'(i);
      end
    end
    bestGrp  = bestPrio & grpMask;
    hiPendId = found ? bestIdx : SPURIOUS_ID;
  end

  // Running priority: lowest set bit of the active-priority bitmap.
  always_comb begin
    runPrio = IDLE_PRIO;
    for (int i = GRP_N - 1; i >= 0; i--) begin
      if (apBits[i]) runPrio = PRIO_W'(i);
    end
  end

  always_comb begin
    apNext = apBits;
    if (strb.dropTake && (|apBits)) apNext[runPrio] = 1'b0;
    if (strb.ackTake) apNext[bestGrp] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      apBits    <= '0;
      activeVec <= '0;
      maskReg   <= '0;
      bprReg    <= '0;
      ackId     <= SPURIOUS_ID;
    end else begin
      apBits <= apNext;
      if (strb.maskLoad) maskReg <= maskData;
      if (strb.bprLoad)  bprReg  <= bprData;
      if (strb.ackTake)      ackId <= bestIdx;
      else if (strb.ackNone) ackId <= SPURIOUS_ID;
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (strb.deactTake && deactId == ID_W'(i)) activeVec[i] <= 1'b0;
        if (strb.ackTake && bestIdx == ID_W'(i))   activeVec[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cpuif_prio.sv
module cpuif_prio
  import cpuif_pkg::*;
#(
  parameter int NUM_IRQ = 16
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_IRQ-1:0]        pendVec,
  input  logic [NUM_IRQ*PRIO_W-1:0] prioFlat,
  input  logic                      ackReq,
  input  logic                      eoiReq,
  input  logic                      deactReq,
  input  logic [ID_W-1:0]           deactId,
  input  logic                      maskWe,
  input  logic [PRIO_W-1:0]         maskData,
  input  logic                      bprWe,
  input  logic [2:0]                bprData,
  output logic                      irqOut,
  output logic [ID_W-1:0]           ackId,
  output logic [PRIO_W-1:0]         runPrio,
  output logic [ID_W-1:0]           hiPendId
);
  ctrlStrobe_t       strb;
  logic              found;
  logic [PRIO_W-1:0] bestPrio;
  logic [PRIO_W-1:0] bestGrp;
  logic [PRIO_W-1:0] maskReg;

  cpuif_ctrl u_ctrl (
    .ackReq(ackReq), .eoiReq(eoiReq), .deactReq(deactReq),
    .maskWe(maskWe), .bprWe(bprWe), .found(found),
    .bestPrio(bestPrio), .bestGrp(bestGrp), .runPrio(runPrio),
    .maskVal(maskReg), .strb(strb), .irqOut(irqOut)
  );

  cpuif_dp #(.NUM_IRQ(NUM_IRQ)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pendVec(pendVec),
    .prioFlat(prioFlat), .deactId(deactId), .maskData(maskData),
    .bprData(bprData), .found(found), .bestPrio(bestPrio),
    .bestGrp(bestGrp), .runPrio(runPrio), .maskReg(maskReg),
    .hiPendId(hiPendId), .ackId(ackId)
  );
endmodule

// File: rtl/cpuif_prio_chk.sv
module cpuif_prio_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ackReq,
  input logic       eoiReq,
  input logic       irqOut,
  input logic [9:0] ackId,
  input logic [7:0] runPrio,
  input logic [9:0] hiPendId,
  input logic [7:0] bestPrio,
  input logic [7:0] maskVal
);
  a_r3_ack_none: assert property (@(posedge clk) disable iff (!rstN)
    ackReq && !irqOut |=> ackId == 10'd1023);

  a_r3_ack_id: assert property (@(posedge clk) disable iff (!rstN)
    ackReq && irqOut |=> ackId == $past(hiPendId));

  a_r4_run_falls: assert property (@(posedge clk) disable iff (!rstN)
    ackReq && irqOut |=> runPrio < $past(runPrio));

  a_r5_drop_rises: assert property (@(posedge clk) disable iff (!rstN)
    eoiReq && !ackReq |=> runPrio >= $past(runPrio));

  a_r7_mask_gate: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> bestPrio < maskVal);

  a_r9_no_cand: assert property (@(posedge clk) disable iff (!rstN)
    hiPendId == 10'd1023 |-> !irqOut);
endmodule

bind cpuif_prio cpuif_prio_chk u_chk (
  .clk(clk), .rstN(rstN), .ackReq(ackReq), .eoiReq(eoiReq),
  .irqOut(irqOut), .ackId(ackId), .runPrio(runPrio),
  .hiPendId(hiPendId), .bestPrio(u_dp.bestPrio), .maskVal(u_dp.maskReg)
);

// File: tb/cpuif_prio_tb.sv
module cpuif_prio_tb;
  localparam int NUM_IRQ = 16;

  typedef struct packed {
    logic [2:0]  op;      // 0 idle, 1 ack, 2 eoi, 3 deact, 4 mask, 5 bpr
    logic [9:0]  arg;
    logic [15:0] pend;
    logic [9:0]  expAck;
    logic [7:0]  expRun;
    logic        expIrq;
    logic [9:0]  expHi;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t TABLE [NV] = '{
    '{3'd4, 10'h0FF, 16'h0000, 10'd0,    8'hFF, 1'b0, 10'd1023},
    '{3'd0, 10'h000, 16'h0016, 10'd0,    8'hFF, 1'b1, 10'd1},
    '{3'd1, 10'h000, 16'h0016, 10'd1,    8'h40, 1'b0, 10'd2},
    '{3'd0, 10'h000, 16'h001E, 10'd0,    8'h40, 1'b1, 10'd3},
    '{3'd1, 10'h000, 16'h001E, 10'd3,    8'h20, 1'b0, 10'd2},
    '{3'd1, 10'h000, 16'h001E, 10'd1023, 8'h20, 1'b0, 10'd2},
    '{3'd2, 10'h000, 16'h001E, 10'd0,    8'h40, 1'b0, 10'd2},
    '{3'd2, 10'h000, 16'h001E, 10'd0,    8'hFF, 1'b1, 10'd2},
    '{3'd3, 10'd3,   16'h001E, 10'd0,    8'hFF, 1'b1, 10'd3},
    '{3'd4, 10'h020, 16'h001E, 10'd0,    8'hFF, 1'b0, 10'd3},
    '{3'd1, 10'h000, 16'h001E, 10'd1023, 8'hFF, 1'b0, 10'd3},
    '{3'd4, 10'h0FF, 16'h0020, 10'd0,    8'hFF, 1'b1, 10'd5},
    '{3'd5, 10'd4,   16'h0020, 10'd0,    8'hFF, 1'b1, 10'd5},
    '{3'd1, 10'h000, 16'h0020, 10'd5,    8'h20, 1'b0, 10'd1023},
    '{3'd0, 10'h000, 16'h0028, 10'd0,    8'h20, 1'b0, 10'd3},
    '{3'd2, 10'h000, 16'h0040, 10'd0,    8'hFF, 1'b0, 10'd6},
    '{3'd3, 10'd5,   16'h0040, 10'd0,    8'hFF, 1'b0, 10'd6}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_IRQ-1:0]   pendVec = '0;
  logic [NUM_IRQ*8-1:0] prioFlat;
  logic ackReq = 1'b0, eoiReq = 1'b0, deactReq = 1'b0, maskWe = 1'b0, bprWe = 1'b0;
  logic [9:0] deactId = '0;
  logic [7:0] maskData = '0;
  logic [2:0] bprData = '0;
  logic irqOut;
  logic [9:0] ackId, hiPendId;
  logic [7:0] runPrio;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cpuif_prio #(.NUM_IRQ(NUM_IRQ)) u_dut (
    .clk(clk), .rstN(rstN), .pendVec(pendVec), .prioFlat(prioFlat),
    .ackReq(ackReq), .eoiReq(eoiReq), .deactReq(deactReq), .deactId(deactId),
    .maskWe(maskWe), .maskData(maskData), .bprWe(bprWe), .bprData(bprData),
    .irqOut(irqOut), .ackId(ackId), .runPrio(runPrio), .hiPendId(hiPendId)
  );

  initial begin
    for (int i = 0; i < NUM_IRQ; i++) prioFlat[i*8 +: 8] = 8'h80;
    prioFlat[1*8 +: 8] = 8'h40;
    prioFlat[2*8 +: 8] = 8'h40;
    prioFlat[3*8 +: 8] = 8'h20;
    prioFlat[4*8 +: 8] = 8'h60;
    prioFlat[5*8 +: 8] = 8'h21;
    prioFlat[6*8 +: 8] = 8'hFF;
  end

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic applyOp(logic [2:0] op, logic [9:0] arg, logic [15:0] pend);
    @(negedge clk);
    pendVec = pend;
    ackReq = (op == 3'd1);
    eoiReq = (op == 3'd2);
    deactReq = (op == 3'd3);
    deactId = arg;
    maskWe = (op == 3'd4);
    maskData = arg[7:0];
    bprWe = (op == 3'd5);
    bprData = arg[2:0];
    @(negedge clk);
    ackReq = 0; eoiReq = 0; deactReq = 0; maskWe = 0; bprWe = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    pendVec = 16'h0002;
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state, mask 0 blocks the pending interrupt
    check("R1", "ackId", ackId, 1023);
    check("R1", "runPrio", runPrio, 8'hFF);
    check("R1", "irqOut", irqOut, 0);
    check("R2", "hiPendId", hiPendId, 1);

    for (int k = 0; k < NV; k++) begin
      string tag;
      applyOp(TABLE[k].op, TABLE[k].arg, TABLE[k].pend);
      case (TABLE[k].op)
        3'd1: tag = "R3";
        3'd2: tag = "R5";
        3'd3: tag = "R6";
        3'd4: tag = "R7";
        3'd5: tag = "R8";
        default: tag = "R2";
      endcase
      if (TABLE[k].op == 3'd1) check(tag, "ackId", ackId, TABLE[k].expAck);
      check("R4", "runPrio", runPrio, TABLE[k].expRun);
      check((TABLE[k].op == 3'd0) ? "R9" : tag, "irqOut", irqOut, TABLE[k].expIrq);
      check(tag, "hiPendId", hiPendId, TABLE[k].expHi);
    end

    // R6: out-of-range ID leaves interrupt 1 active (hidden)
    applyOp(3'd3, 10'd20, 16'h0002);
    check("R6", "hiPendId out-of-range", hiPendId, 1023);
    check("R9", "irqOut none", irqOut, 0);
    // R6: real deactivation makes interrupt 1 selectable again
    applyOp(3'd3, 10'd1, 16'h0002);
    check("R6", "hiPendId after deact", hiPendId, 1);
    check("R8", "irqOut grp 0x40 under idle", irqOut, 1);
    check("R6", "runPrio unchanged", runPrio, 8'hFF);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule